// File: doc/BRIEF.md
# Product Term Steering Allocator

This block models one logic block of a programmable logic device, from the literal inputs to the sum input of each macrocell. Thirty-six input signals are offered to a configurable AND array in both true and inverted form. The array forms a pool of 80 product terms. A configuration-driven allocator then ORs a chosen subset of those terms into each of 16 macrocell sums. The macrocell registers, timing models, power modes and I/O cells are not part of the block.

Each macrocell chooses its terms one at a time, and may take anywhere from none to sixteen of them. Macrocells are arranged in four groups of four. A group reaches its own window of 20 consecutive terms, and any term in that window may feed several macrocells of the group at once. The configuration image is loaded serially while a load enable is high and then stays fixed until the next load. The array and allocator are purely combinational, so the sums follow the literal inputs in the same cycle.

Configuration uses plain control pins, not a handshake. The shift port accepts one bit on every rising clock edge while the load enable is high and never stalls. The literal inputs and the sums have no valid or ready signals, because the block holds no data between them.

Top module: `pterm_steer_alloc`

## Requirements
- R1: Product term t is the AND of the literal columns enabled for it. Column 2i carries lit_in[i] and column 2i+1 carries its complement.
- R2: A product term with no literal enabled evaluates to 1. A term that enables both polarities of the same input evaluates to 0.
- R3: mc_sum[m] is the OR of the product terms selected in macrocell m's mask that lie inside its group's window. A macrocell with no such term selected gives 0.
- R4: One product term may drive the sums of several macrocells of the same group at the same time.
- R5: Group g (macrocells 4g to 4g+3) reaches terms 20g to 20g+19. A mask bit set outside that window has no effect on the sum.
- R6: A mask that selects 16 or fewer terms leaves cfg_err low. A mask that selects 17 or more terms sets cfg_err.
- R7: A mask bit set outside the macrocell's reachable window sets cfg_err.
- R8: On each rising clk edge with cfg_load high, cfg_din shifts into bit 0 of the 7040-bit image and every bit moves up one place, so the first bit sent ends at bit 7039. Bit t*72+c enables column c of term t. Bit 5760+m*80+t selects term t for macrocell m. With cfg_load low, the image holds.
- R9: The sums depend combinationally on lit_in and add no register stage.
- R10: While rst_n is low, the image is cleared to zero, so every sum reads 0 and cfg_err reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shift chain |
| rst_n | input | 1 | Asynchronous active-low reset; clears the image |
| cfg_load | input | 1 | Shift enable for the configuration image |
| cfg_din | input | 1 | Serial configuration bit, sent first for the most significant bit |
| lit_in | input | 36 | Input signals to the AND array |
| mc_sum | output | 16 | Sum input of each macrocell |
| cfg_err | output | 1 | Set when any mask is over-full or reaches outside its window |

## Verification
A configuration bit takes effect one rising edge after it is presented. The bench therefore drives each bit on a falling edge and lets the edge in between capture it, and it checks only after the final bit has been clocked in. mc_sum and cfg_err have no register stage after the image, so each check changes lit_in away from any edge and samples 1 ns later, before the next rising edge. The reset check samples while rst_n is held low.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int unsigned N_IN_D   = 36;
  localparam int unsigned N_PT_D   = 80;
  localparam int unsigned N_MC_D   = 16;
  localparam int unsigned GRP_SZ_D = 4;
  localparam int unsigned MAX_SEL_D = 16;

  function automatic int unsigned popcnt(input logic [N_PT_D-1:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < N_PT_D; i++) begin
      if (i < n && v[i]) c++;
    end
    return c;
  endfunction
endpackage

// File: rtl/pta_cfg_chain.sv
module pta_cfg_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/pta_and_array.sv
module pta_and_array #(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 80,
  localparam int unsigned N_COL = 2 * N_IN
) (
  input  logic [N_IN-1:0]       lit_in,
  input  logic [N_PT*N_COL-1:0] col_en,
  output logic [N_PT-1:0]       pterm
);
  logic [N_COL-1:0] cols;

  for (genvar i = 0; i < N_IN; i++) begin : g_col
    assign cols[2*i]   = lit_in[i];
    assign cols[2*i+1] = ~lit_in[i];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    // a disabled column reads as 1 and so does not take part in the AND
    assign pterm[t] = &(cols | ~col_en[t*N_COL +: N_COL]);
  end
endmodule

// File: rtl/pta_steer.sv
module pta_steer #(
  parameter int unsigned N_PT    = 80,
  parameter int unsigned N_MC    = 16,
  parameter int unsigned GRP_SZ  = 4,
  parameter int unsigned MAX_SEL = 16,
  localparam int unsigned N_GRP  = N_MC / GRP_SZ,
  localparam int unsigned WIN    = N_PT / N_GRP
) (
  input  logic [N_PT-1:0]      pterm,
  input  logic [N_MC*N_PT-1:0] sel,
  output logic [N_MC-1:0]      mc_sum,
  output logic                 err
);
  localparam logic [N_PT-1:0] BASE_WIN = {{(N_PT-WIN){1'b0}}, {WIN{1'b1}}};

  logic [N_MC-1:0] bad;

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam logic [N_PT-1:0] REACH = BASE_WIN << ((m / GRP_SZ) * WIN);
    logic [N_PT-1:0] msk;
    logic [N_PT-1:0] eff;
    logic            over;
    logic            stray;

    assign msk    = sel[m*N_PT +: N_PT];
    assign eff    = msk & REACH;
    assign mc_sum[m] = |(eff & pterm);
    assign over   = pta_pkg::popcnt(msk, N_PT) > MAX_SEL;
    assign stray  = |(msk & ~REACH);
    assign bad[m] = over | stray;
  end

  assign err = |bad;
endmodule

// File: rtl/pterm_steer_alloc.sv
module pterm_steer_alloc #(
  parameter int unsigned N_IN    = pta_pkg::N_IN_D,
  parameter int unsigned N_PT    = pta_pkg::N_PT_D,
  parameter int unsigned N_MC    = pta_pkg::N_MC_D,
  parameter int unsigned GRP_SZ  = pta_pkg::GRP_SZ_D,
  parameter int unsigned MAX_SEL = pta_pkg::MAX_SEL_D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_din,
  input  logic [N_IN-1:0] lit_in,
  output logic [N_MC-1:0] mc_sum,
  output logic            cfg_err
);
  localparam int unsigned N_COL  = 2 * N_IN;
  localparam int unsigned W_AND  = N_PT * N_COL;
  localparam int unsigned W_MASK = N_MC * N_PT;
  localparam int unsigned W_CFG  = W_AND + W_MASK;

  logic [W_CFG-1:0]  cfg_q;
  logic [W_AND-1:0]  and_cfg;
  logic [W_MASK-1:0] mask_cfg;
  logic [N_PT-1:0]   pterm;

  pta_cfg_chain #(.W(W_CFG)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cfg_load),
    .din  (cfg_din),
    .q    (cfg_q)
  );

  assign and_cfg  = cfg_q[W_AND-1:0];
  assign mask_cfg = cfg_q[W_CFG-1:W_AND];

  pta_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .lit_in(lit_in),
    .col_en(and_cfg),
    .pterm (pterm)
  );

  pta_steer #(.N_PT(N_PT), .N_MC(N_MC), .GRP_SZ(GRP_SZ), .MAX_SEL(MAX_SEL)) u_steer (
    .pterm (pterm),
    .sel   (mask_cfg),
    .mc_sum(mc_sum),
    .err   (cfg_err)
  );
endmodule

// File: rtl/pta_checker.sv
module pta_checker #(
  parameter int unsigned N_PT    = 80,
  parameter int unsigned N_MC    = 16,
  parameter int unsigned GRP_SZ  = 4,
  parameter int unsigned MAX_SEL = 16,
  parameter int unsigned W_CFG   = 7040,
  parameter int unsigned W_AND   = 5760
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             cfg_din,
  input logic [W_CFG-1:0] cfg_q,
  input logic [N_MC-1:0]  mc_sum,
  input logic             cfg_err
);
  localparam int unsigned WIN = N_PT / (N_MC / GRP_SZ);

  // R8: shift by one place while loading
  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (cfg_q[0] == $past(cfg_din)) && (cfg_q[W_CFG-1:1] == $past(cfg_q[W_CFG-2:0])));

  // R8: image holds while not loading
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_q));

  // R10: cleared outputs while reset is held
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |-> (mc_sum == '0) && !cfg_err);

  for (genvar m = 0; m < N_MC; m++) begin : g_m
    localparam int unsigned LO = (m / GRP_SZ) * WIN;
    logic [N_PT-1:0] msk;
    assign msk = cfg_q[W_AND + m*N_PT +: N_PT];

    // R6: over-full mask raises the error flag
    p_overfull_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(msk) > MAX_SEL) |-> cfg_err);

    // R3: nothing reachable selected gives a zero sum
    p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (msk[LO +: WIN] == '0) |-> !mc_sum[m]);

    // R7: a selection outside the window raises the error flag
    p_stray_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(msk) != $countones(msk[LO +: WIN])) |-> cfg_err);
  end
endmodule

bind pterm_steer_alloc pta_checker #(
  .N_PT(N_PT), .N_MC(N_MC), .GRP_SZ(GRP_SZ), .MAX_SEL(MAX_SEL),
  .W_CFG(W_CFG), .W_AND(W_AND)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_load(cfg_load),
  .cfg_din (cfg_din),
  .cfg_q   (cfg_q),
  .mc_sum  (mc_sum),
  .cfg_err (cfg_err)
);

// File: tb/pterm_steer_alloc_tb.sv
module pterm_steer_alloc_tb;
  localparam int W_AND = 80 * 72;
  localparam int W_CFG = W_AND + 16 * 80;
  localparam int NV = 10;
  // {lit_in, expected mc_sum} for configuration A (R1..R5)
  localparam logic [51:0] VEC [NV] = '{
    {36'h0_0000_0000, 16'h8011},
    {36'h0_0000_0001, 16'h8010},
    {36'h0_0000_0003, 16'h8013},
    {36'h0_0000_0004, 16'h8015},
    {36'h0_0000_0008, 16'h8015},
    {36'h0_0000_0018, 16'h8011},
    {36'h0_0000_0020, 16'h8011},
    {36'h8_0000_0000, 16'h8031},
    {36'h0_0000_0400, 16'h9011},
    {36'hF_FFFF_FFFF, 16'h9037}
  };

  logic clk = 0, rst_n = 0, cfg_load = 0, cfg_din = 0;
  logic [35:0] lit_in = '0;
  logic [15:0] mc_sum;
  logic cfg_err;
  logic [W_CFG-1:0] cv;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pterm_steer_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_din(cfg_din),
    .lit_in(lit_in), .mc_sum(mc_sum), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got err/sum=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic set_and(input int t, input int c);
    cv[t*72 + c] = 1'b1;
  endtask

  task automatic set_sel(input int m, input int t);
    cv[W_AND + m*80 + t] = 1'b1;
  endtask

  task automatic base_and();
    cv = '0;
    set_and(0, 0); set_and(0, 2);
    set_and(1, 1);
    set_and(2, 4);
    set_and(3, 6); set_and(3, 9);
    set_and(4, 10); set_and(4, 11);
    set_and(20, 70);
    set_and(21, 71);
    set_and(79, 20);
  endtask

  task automatic shift_in();
    for (int i = W_CFG - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_din  = cv[i];
    end
    @(negedge clk);
    cfg_load = 1'b0;
    cfg_din  = 1'b0;
  endtask

  task automatic apply(input logic [35:0] v);
    @(negedge clk);
    lit_in = v;
    #1;
  endtask

  initial begin
    #1;
    chk("R10 reset", {cfg_err, mc_sum}, 17'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // configuration A: clean steering
    base_and();
    set_sel(0, 0); set_sel(0, 1);
    set_sel(1, 0);
    set_sel(2, 2); set_sel(2, 3);
    set_sel(3, 4);
    set_sel(4, 20); set_sel(4, 21);
    set_sel(5, 20);
    set_sel(12, 79);
    for (int t = 60; t < 76; t++) set_sel(15, t);
    shift_in();

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][51:16]);
      chk("R1 R2 R3 R4 R8 R9 vector", {cfg_err, mc_sum}, {1'b0, VEC[k][15:0]});
    end
    chk("R6 exactly 16 terms no error", {cfg_err, 16'h0}, 17'h0);

    // R8: load low, din toggling, image unaffected
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
    end
    apply(36'h0_0000_0003);
    chk("R8 hold while load low", {cfg_err, mc_sum}, 17'h08013);

    // R9: change without any clock edge in between
    @(negedge clk);
    lit_in = 36'h0_0000_0001; #1;
    lit_in = 36'h0_0000_0004; #1;
    chk("R9 same-cycle response", {cfg_err, mc_sum}, 17'h08015);

    // configuration B: 17 terms on macrocell 0
    base_and();
    for (int t = 0; t < 17; t++) set_sel(0, t);
    shift_in();
    apply(36'h0_0000_0001);
    chk("R6 17 terms error", {cfg_err, mc_sum}, 17'h10001);

    // configuration C: macrocell 4 selects term 0 outside its window
    base_and();
    set_sel(4, 0); set_sel(4, 20);
    shift_in();
    apply(36'h0_0000_0003);
    chk("R5 R7 outside term ignored", {cfg_err, mc_sum}, 17'h10000);
    apply(36'h8_0000_0003);
    chk("R5 in-window term still used", {cfg_err, mc_sum}, 17'h10010);

    // R10: reset clears a loaded image
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears image", {cfg_err, mc_sum}, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(36'hF_FFFF_FFFF);
    chk("R10 after reset", {cfg_err, mc_sum}, 17'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule